// File: doc/BRIEF.md
# Four-Channel Split-Width Interval Timer

This block is a register-mapped down-counting timer with four channels behind a simple two-phase peripheral bus (select, enable, write strobe, byte address, 32-bit data). Each channel owns a control word, a reload word and a live count word. The 32-bit reload and count words can be used whole, as two independent 16-bit halves or as four independent 8-bit lanes. Each of these sub-timers has its own run bit, interrupt-enable bit and pending bit in three shared 16-bit global registers.

A running sub-timer steps down by one on every count tick. A tick arriving while its count is zero reloads the count from the matching reload slice and marks the sub-timer pending. The tick source of a channel is either every bus clock cycle or each rising edge of an external tick input, which is resynchronised to the bus clock. Software can read the count at any moment and can overwrite it to preload a new value. A single level interrupt output is raised while any pending sub-timer has its interrupt enabled.

Top module: `ptq_timer`

## Requirements
- R1: After reset, every control, reload and count word, the run register, the interrupt-enable register and the pending register read as zero, and `irq` is low.
- R2: Reads return the identity constant at 0x00, the channel count (4) in bits [3:0] at 0x10, the interrupt enables at 0x14, the pending bits at 0x18 and the run bits at 0x1C. Channel c places its control, reload and count words at 0x20+16c, 0x24+16c and 0x28+16c. Any other address reads zero, and `prdata` is zero while `psel` is low.
- R3: Control bits [2:0] equal to 1 select one 32-bit timer. When run bit 4c is set, the count steps down once per tick. A tick at count zero loads the reload word instead and sets pending bit 4c, so the period is reload+1 ticks.
- R4: Control bits [2:0] equal to 2 select two 16-bit timers. Timer i (i = 0, 1) uses bits [16i+15:16i] of the reload and count words, run bit 4c+i and pending bit 4c+i, and each one counts, reloads and flags on its own.
- R5: Control bits [2:0] equal to 3 select four 8-bit timers. Timer i (i = 0..3) uses byte i of the reload and count words, run bit 4c+i and pending bit 4c+i.
- R6: Run bits of sub-timers that the current mode does not have (timers 1..3 in 32-bit mode, timers 2..3 in 16-bit mode) have no effect. Mode values 0 and 4 to 7 stop the whole channel.
- R7: Clearing a run bit freezes the sub-timer's count and leaves its pending bit as it is.
- R8: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. An underflow in the same cycle as a clear of the same bit leaves the bit set.
- R9: `irq` is high exactly while some pending bit and its matching interrupt-enable bit are both set.
- R10: A write to a count word loads the written value in that cycle. That cycle's tick is dropped and no underflow is flagged.
- R11: With control bit 3 equal to 0, the channel steps once for each rising edge of `ext_tick` and does not step on other bus clock cycles. With control bit 3 equal to 1, it steps on every bus clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write transfer |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| ext_tick | input | 1 | External count tick, sampled on `clk` |
| irq | output | 1 | Level interrupt request |

## Verification
An underflow that sets a pending bit can land in the same bus cycle as a software write that clears that bit. The bench preloads a bus-clocked 32-bit timer with 3 and starts it. It then times a write-one-to-clear so that its access phase completes on the fourth tick, which is the tick at zero. After stopping the timer, the pending bit must still read 1. A second clear in a quiet cycle must then bring it to 0. A count write that lands on a running tick is handled the same way: the written value must win, and exactly two further ticks must follow it before the stop.

// File: rtl/ptq_pkg.sv
package ptq_pkg;
  localparam int WORD = 32;
  localparam int SUBS = 4;

  localparam logic [2:0] MODE_W32 = 3'd1;
  localparam logic [2:0] MODE_W16 = 3'd2;
  localparam logic [2:0] MODE_W8  = 3'd3;

  localparam int OFF_ID   = 'h00;
  localparam int OFF_CFG  = 'h10;
  localparam int OFF_IEN  = 'h14;
  localparam int OFF_PEND = 'h18;
  localparam int OFF_RUN  = 'h1C;
  localparam int OFF_CH0  = 'h20;
  localparam int CH_STEP  = 'h10;
  localparam int SLOT_CTL = 'h0;
  localparam int SLOT_RLD = 'h4;
  localparam int SLOT_CNT = 'h8;

  function automatic int ch_addr(input int c, input int slot);
    return OFF_CH0 + CH_STEP * c + slot;
  endfunction
endpackage

// File: rtl/ptq_tick_sync.sv
module ptq_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic pulse
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], ext_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign pulse = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/ptq_chan.sv
module ptq_chan
  import ptq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_we,
  input  logic            rld_we,
  input  logic            cnt_we,
  input  logic [WORD-1:0] wdata,
  input  logic            ext_pulse,
  input  logic [SUBS-1:0] run,
  output logic [3:0]      ctl_q,
  output logic [WORD-1:0] rld_q,
  output logic [WORD-1:0] cnt_q,
  output logic [SUBS-1:0] uf
);
  localparam int HW = WORD / 2;
  localparam int BW = WORD / 4;

  logic [3:0]      ctl_d;
  logic [WORD-1:0] rld_d;
  logic [WORD-1:0] cnt_d;
  logic            tick;

  assign tick = ctl_q[3] ? 1'b1 : ext_pulse;

  always_comb begin
    ctl_d = ctl_we ? wdata[3:0] : ctl_q;
    rld_d = rld_we ? wdata      : rld_q;
  end

  always_comb begin
    cnt_d = cnt_q;
    uf    = '0;
    case (ctl_q[2:0])
      MODE_W32: begin
        if (run[0] && tick) begin
          if (cnt_q == '0) begin
            cnt_d = rld_q;
            uf[0] = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end
      MODE_W16: begin
        for (int i = 0; i < 2; i++) begin
          if (run[i] && tick) begin
            if (cnt_q[HW*i +: HW] == '0) begin
              cnt_d[HW*i +: HW] = rld_q[HW*i +: HW];
              uf[i] = 1'b1;
            end else begin
              cnt_d[HW*i +: HW] = cnt_q[HW*i +: HW] - 1'b1;
            end
          end
        end
      end
      MODE_W8: begin
        for (int i = 0; i < 4; i++) begin
          if (run[i] && tick) begin
            if (cnt_q[BW*i +: BW] == '0) begin
              cnt_d[BW*i +: BW] = rld_q[BW*i +: BW];
              uf[i] = 1'b1;
            end else begin
              cnt_d[BW*i +: BW] = cnt_q[BW*i +: BW] - 1'b1;
            end
          end
        end
      end
      default: ;
    endcase
    if (cnt_we) begin
      cnt_d = wdata;
      uf    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      rld_q <= '0;
      cnt_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      rld_q <= rld_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ptq_timer.sv
module ptq_timer
  import ptq_pkg::*;
#(
  parameter int          NUM_CH   = 4,
  parameter int          AW       = 8,
  parameter logic [31:0] ID_VALUE = 32'h5A17_0100,
  parameter int          SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  input  logic          ext_tick,
  output logic          irq
);
  localparam int SB = SUBS * NUM_CH;

  logic                       wr;
  logic                       wr_ien;
  logic                       wr_pend;
  logic                       wr_run;
  logic [NUM_CH-1:0]          ctl_we;
  logic [NUM_CH-1:0]          rld_we;
  logic [NUM_CH-1:0]          cnt_we;
  logic [SB-1:0]              ien_q, ien_d;
  logic [SB-1:0]              pend_q, pend_d;
  logic [SB-1:0]              run_q, run_d;
  logic [SB-1:0]              uf_all;
  logic [NUM_CH-1:0][3:0]     ctl_w;
  logic [NUM_CH-1:0][WORD-1:0] rld_w;
  logic [NUM_CH-1:0][WORD-1:0] cnt_w;
  logic                       ext_pulse;
  logic [31:0]                rd;

  assign wr      = psel & penable & pwrite;
  assign wr_ien  = wr && (paddr == AW'(OFF_IEN));
  assign wr_pend = wr && (paddr == AW'(OFF_PEND));
  assign wr_run  = wr && (paddr == AW'(OFF_RUN));

  ptq_tick_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ext_in (ext_tick),
    .pulse  (ext_pulse)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ctl_we[c] = wr && (paddr == AW'(ch_addr(c, SLOT_CTL)));
    assign rld_we[c] = wr && (paddr == AW'(ch_addr(c, SLOT_RLD)));
    assign cnt_we[c] = wr && (paddr == AW'(ch_addr(c, SLOT_CNT)));

    ptq_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we[c]),
      .rld_we    (rld_we[c]),
      .cnt_we    (cnt_we[c]),
      .wdata     (pwdata),
      .ext_pulse (ext_pulse),
      .run       (run_q[SUBS*c +: SUBS]),
      .ctl_q     (ctl_w[c]),
      .rld_q     (rld_w[c]),
      .cnt_q     (cnt_w[c]),
      .uf        (uf_all[SUBS*c +: SUBS])
    );
  end

  always_comb begin
    ien_d  = wr_ien ? pwdata[SB-1:0] : ien_q;
    run_d  = wr_run ? pwdata[SB-1:0] : run_q;
    pend_d = (pend_q & ~(wr_pend ? pwdata[SB-1:0] : '0)) | uf_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      run_q  <= '0;
      pend_q <= '0;
    end else begin
      ien_q  <= ien_d;
      run_q  <= run_d;
      pend_q <= pend_d;
    end
  end

  assign irq = |(pend_q & ien_q);

  always_comb begin
    rd = '0;
    if (paddr == AW'(OFF_ID))   rd = ID_VALUE;
    if (paddr == AW'(OFF_CFG))  rd = 32'(NUM_CH);
    if (paddr == AW'(OFF_IEN))  rd = 32'(ien_q);
    if (paddr == AW'(OFF_PEND)) rd = 32'(pend_q);
    if (paddr == AW'(OFF_RUN))  rd = 32'(run_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (paddr == AW'(ch_addr(c, SLOT_CTL))) rd = 32'(ctl_w[c]);
      if (paddr == AW'(ch_addr(c, SLOT_RLD))) rd = rld_w[c];
      if (paddr == AW'(ch_addr(c, SLOT_CNT))) rd = cnt_w[c];
    end
  end

  assign prdata = psel ? rd : '0;
endmodule

// File: rtl/ptq_chk.sv
module ptq_chk #(
  parameter int SB = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [SB-1:0] uf_all,
  input logic [SB-1:0] pend_q,
  input logic [SB-1:0] run_q,
  input logic          wr_pend,
  input logic [31:0]   pwdata,
  input logic          cnt_we0,
  input logic [31:0]   cnt0,
  input logic          irq
);
  // R8
  pend_sets_on_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|uf_all) |=> ((pend_q & $past(uf_all)) == $past(uf_all)));

  // R3
  pend_only_from_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(uf_all)) == '0));

  // R7
  stopped_count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(run_q[3:0]) == 4'd0) && !$past(cnt_we0)) |-> $stable(cnt0));

  // R9
  full_clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && (pwdata[SB-1:0] == {SB{1'b1}}) && (uf_all == '0)) |=> !irq);
endmodule

bind ptq_timer ptq_chk #(.SB(4 * NUM_CH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .uf_all  (uf_all),
  .pend_q  (pend_q),
  .run_q   (run_q),
  .wr_pend (wr_pend),
  .pwdata  (pwdata),
  .cnt_we0 (cnt_we[0]),
  .cnt0    (cnt_w[0]),
  .irq     (irq)
);

// File: tb/ptq_timer_test.sv
`timescale 1ns/1ps
module ptq_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        ext_tick;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ptq_timer uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .ext_tick(ext_tick), .irq(irq)
  );

  localparam int NV = 10;
  localparam logic [1:0]  V_CH  [NV] = '{0, 1, 2, 3, 0, 1, 2, 3, 0, 1};
  localparam logic [2:0]  V_MD  [NV] = '{1, 1, 2, 3, 3, 1, 2, 0, 1, 2};
  localparam logic [31:0] V_RLD [NV] = '{32'h10, 32'h3, 32'h0005_0002, 32'h0301_0402,
                                         32'h0202_0202, 32'h100, 32'h0007_0007, 32'h9,
                                         32'h0, 32'hFFFF_0000};
  localparam logic [3:0]  V_RUN [NV] = '{4'h1, 4'h1, 4'h3, 4'hF, 4'h5, 4'h2, 4'hC, 4'h1, 4'h1, 4'h3};
  localparam int          V_T   [NV] = '{5, 6, 4, 3, 4, 5, 4, 4, 3, 2};
  localparam logic [31:0] V_CNT [NV] = '{32'hB, 32'h1, 32'h0001_0001, 32'h0000_0102,
                                         32'h0201_0201, 32'h100, 32'h0007_0007, 32'h9,
                                         32'h0, 32'hFFFD_0000};
  localparam logic [3:0]  V_PND [NV] = '{4'h0, 4'h1, 4'h1, 4'h5, 4'h5, 4'h0, 4'h0, 4'h0, 4'h1, 4'h1};
  localparam string       V_TAG [NV] = '{"R3", "R3", "R4", "R5", "R5", "R6", "R6", "R6", "R3", "R4"};

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk); penable = 1'b1; d = prdata;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  function automatic logic [7:0] ca(input int c, input int slot);
    return 8'(32 + 16 * c + slot);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0; ext_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2 reset state and map
    check("R1 irq", 32'(irq), 0);
    brd(8'h00, r); check("R2 id", r, 32'h5A17_0100);
    brd(8'h10, r); check("R2 cfg", r, 32'd4);
    brd(8'h14, r); check("R1 ien", r, 0);
    brd(8'h18, r); check("R1 pend", r, 0);
    brd(8'h1C, r); check("R1 run", r, 0);
    brd(ca(2, 0), r); check("R1 ctl", r, 0);
    brd(ca(2, 4), r); check("R1 rld", r, 0);
    brd(ca(3, 8), r); check("R1 cnt", r, 0);
    brd(8'h0C, r); check("R2 hole", r, 0);
    check("R2 idle bus", prdata, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      int c;
      c = int'(V_CH[v]);
      bwr(8'h1C, 0);
      bwr(8'h18, 32'hFFFF);
      bwr(ca(c, 0), {28'd0, 1'b1, V_MD[v]});
      bwr(ca(c, 4), V_RLD[v]);
      bwr(ca(c, 8), V_RLD[v]);
      bwr(8'h1C, 32'(V_RUN[v]) << (4 * c));
      repeat (V_T[v] - 2) @(negedge clk);
      bwr(8'h1C, 0);
      brd(ca(c, 8), r); check({V_TAG[v], " count"}, r, V_CNT[v]);
      brd(8'h18, r); check({V_TAG[v], " pending"}, (r >> (4 * c)) & 32'hF, 32'(V_PND[v]));
    end

    // R8 underflow and clear in the same cycle
    bwr(8'h18, 32'hFFFF);
    bwr(ca(0, 0), 32'h9);
    bwr(ca(0, 4), 32'd3);
    bwr(ca(0, 8), 32'd3);
    bwr(8'h1C, 32'h1);
    repeat (2) @(negedge clk);
    bwr(8'h18, 32'h1);
    bwr(8'h1C, 0);
    brd(8'h18, r); check("R8 set beats clear", r & 1, 1);
    bwr(8'h18, 32'h0);
    brd(8'h18, r); check("R8 write zero keeps", r & 1, 1);

    // R9 irq gating
    check("R9 irq masked", 32'(irq), 0);
    bwr(8'h14, 32'h1);
    check("R9 irq raised", 32'(irq), 1);
    bwr(8'h14, 32'h2);
    check("R9 other enable", 32'(irq), 0);
    bwr(8'h14, 32'h1);
    bwr(8'h18, 32'h1);
    brd(8'h18, r); check("R8 write one clears", r & 1, 0);
    check("R9 irq after clear", 32'(irq), 0);

    // R7 stopped timer keeps count and pending
    bwr(ca(0, 4), 32'd1);
    bwr(ca(0, 8), 32'd1);
    bwr(8'h1C, 32'h1);
    bwr(8'h1C, 32'h0);
    brd(ca(0, 8), r); check("R7 count after stop", r, 32'd1);
    brd(8'h18, r); check("R7 pending kept", r & 1, 1);
    repeat (5) @(negedge clk);
    brd(ca(0, 8), r); check("R7 frozen", r, 32'd1);
    bwr(8'h18, 32'hFFFF);
    bwr(8'h14, 32'h0);

    // R10 count write wins over a tick
    bwr(ca(0, 4), 32'h100);
    bwr(ca(0, 8), 32'h100);
    bwr(8'h1C, 32'h1);
    repeat (3) @(negedge clk);
    bwr(ca(0, 8), 32'h50);
    bwr(8'h1C, 32'h0);
    brd(ca(0, 8), r); check("R10 preload then two ticks", r, 32'h4E);

    // R11 external tick source
    bwr(ca(1, 0), 32'h1);
    bwr(ca(1, 4), 32'd100);
    bwr(ca(1, 8), 32'd100);
    bwr(8'h1C, 32'h10);
    for (int k = 0; k < 3; k++) begin
      ext_tick = 1'b1; repeat (3) @(negedge clk);
      ext_tick = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    bwr(8'h1C, 32'h0);
    brd(ca(1, 8), r); check("R11 edges counted", r, 32'd97);
    brd(ca(1, 0), r); check("R2 ctl readback", r, 32'h1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule